// File: doc/BRIEF.md
# Start-Bit Triggered ETU Timeout Counter

This block measures time on a smart-card serial line in elementary time units (ETUs). It holds three 8-bit reload bytes and runs them in one of two layouts. The split layout has a free-running 8-bit counter that reloads itself, next to a 16-bit counter built from the middle and high reload bytes. The chained layout joins all three bytes into one 24-bit counter. A counter that reaches terminal count raises a sticky timeout flag, and the flags drive a maskable interrupt.

Writing a mode code does not start counting. It only arms the unit. The first start-bit pulse after the write starts counting, and that pulse may come from the transmit path or from the receive path. Later start bits retrigger the wide counter from its reload bytes, so software can rewrite those bytes while a count is running. The rewrite has no effect on the running count. The new value is used at the next start bit. Setting the top bit of a mode code adds an auto-stop: every counter halts at the end of the 12th ETU after that first start bit. Start-bit detection, ETU generation and host bus decoding are outside this block.

Register addresses on `wrAddr`: 0 = mode, 1 = low reload byte (the 8-bit counter in split, bits 7:0 in chained), 2 = middle reload byte, 3 = high reload byte, 4 = interrupt mask. Mode codes: 00h = stopped, 01h = split 8+16, 02h = chained 24, 81h/82h = the same with auto-stop. Every other code stops the unit.

Top module: `etuTimeout`

## Requirements
- R1: After reset, `status` is 00 and `irq` is 0, and no flag is set until a mode has been armed and a start bit has been seen.
- R2: In split mode (01h), the first start bit loads the 8-bit counter with the low reload byte N. `status[0]` is set in the cycle after the Nth following `etuTick`. The counter then reloads N and raises `status[0]` again every N ticks. A reload of 0 counts 256 ticks.
- R3: In split mode, start bits after the first do not reset or retrigger the 8-bit counter.
- R4: In split mode, every start bit loads the 16-bit counter with {high, middle} = M. `status[1]` is set in the cycle after the Mth tick. The counter then holds until the next start bit and raises no further flag.
- R5: A reload byte written while the wide counter is running does not change that count. The new value is loaded at the next start bit.
- R6: In chained mode (02h), every start bit loads the 24-bit value {high, middle, low}. `status[1]` is set after that many ticks, and the 8-bit counter stays idle.
- R7: Writing 00h, or any code other than 01h, 02h, 81h and 82h, to the mode register stops all counting at once. Later start bits and ticks then set no flag.
- R8: With mode bit 7 set (81h, 82h), all counters stop after the 12th tick following the first start bit. A terminal count on that 12th tick still sets its flag. Start bits after the stop are ignored until the next mode write.
- R9: Flags are sticky. A `rdStatus` pulse clears both flags, except that a flag whose terminal count falls in the same cycle stays set.
- R10: `irq` is 1 exactly when a set flag has its mask bit set (mask bit 0 for `status[0]`, bit 1 for `status[1]`).
- R11: Start bits before the mode write are ignored. After the write, ticks change nothing until a start bit arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdStatus | input | 1 | Status read strobe, clears the flags |
| etuTick | input | 1 | One-cycle pulse per ETU |
| startBit | input | 1 | One-cycle pulse for a start bit from transmit or receive |
| status | output | 2 | Sticky flags: bit 0 = 8-bit counter, bit 1 = 16/24-bit counter |
| irq | output | 1 | Interrupt, the masked OR of the flags |

## Verification
A start bit is sent mid-period in split mode, with a spacing chosen so that a retriggered 8-bit counter would fire one tick later than a free-running one. This separates R3 from R4. Reload bytes are rewritten between start bits so the old and new counts differ in length, which shows when the new value is taken. The chained test uses a value whose low byte is non-zero, which separates a true 24-bit load from a 16-bit one. The auto-stop test puts a wide terminal exactly on the 12th tick and places the next 8-bit period past it. A read pulse that lands on a terminal tick checks that a set wins over a clear.

// File: rtl/tocPkg.sv
package tocPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load1;     // load the 8-bit counter from the low reload byte
    logic loadWide;  // load the wide counter
    logic run1;      // 8-bit counter active
    logic runWide;   // wide counter active
    logic chained;   // wide counter spans all three bytes
  } tocCtl_t;

  localparam int MODE_SPLIT_CODE = 1;
  localparam int MODE_CHAIN_CODE = 2;
  localparam int ADDR_MODE       = 0;
  localparam int ADDR_RELOAD0    = 1;
  localparam int ADDR_MASK       = 4;
  localparam int NUM_RELOAD      = 3;
endpackage

// File: rtl/tocCtrl.sv
module tocCtrl
  import tocPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 3,
  parameter int AUTO_STOP_ETUS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              startBit,
  input  logic              etuTick,
  input  logic              termWide,
  output tocCtl_t           ctl
);
  localparam int AUTO_W = $clog2(AUTO_STOP_ETUS + 1);
  localparam logic [AUTO_W-1:0] AUTO_LAST = AUTO_W'(AUTO_STOP_ETUS - 1);

  logic splitMode, chainMode, armed, live, autoOn, run1, runWide;
  logic [AUTO_W-1:0] autoCnt;

  logic modeWr, isSplit, isChain, startHit, autoTick, autoDone;

  always_comb begin
    modeWr   = wrEn && (wrAddr == ADDR_W'(ADDR_MODE));
    isSplit  = wrData[DATA_W-2:0] == (DATA_W-1)'(MODE_SPLIT_CODE);
    isChain  = wrData[DATA_W-2:0] == (DATA_W-1)'(MODE_CHAIN_CODE);
    startHit = startBit && (armed || live) && !modeWr;
    autoTick = etuTick && autoOn && live && !modeWr;
    autoDone = autoTick && (autoCnt == AUTO_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitMode <= 1'b0;
      chainMode <= 1'b0;
      armed     <= 1'b0;
      live      <= 1'b0;
      autoOn    <= 1'b0;
      run1      <= 1'b0;
      runWide   <= 1'b0;
      autoCnt   <= '0;
    end else if (modeWr) begin
      splitMode <= isSplit;
      chainMode <= isChain;
      armed     <= isSplit || isChain;
      live      <= 1'b0;
      autoOn    <= wrData[DATA_W-1] && (isSplit || isChain);
      run1      <= 1'b0;
      runWide   <= 1'b0;
      autoCnt   <= '0;
    end else begin
      if (startHit && armed) begin
        armed <= 1'b0;
        live  <= 1'b1;
      end
      if (autoDone) begin
        live    <= 1'b0;
        autoOn  <= 1'b0;
        run1    <= 1'b0;
        runWide <= 1'b0;
      end else begin
        if (startHit && armed && splitMode) run1 <= 1'b1;
        if (startHit)      runWide <= 1'b1;
        else if (termWide) runWide <= 1'b0;
      end
      if (autoTick) autoCnt <= autoCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load1    = startHit && armed && splitMode;
    ctl.loadWide = startHit;
    ctl.run1     = run1;
    ctl.runWide  = runWide;
    ctl.chained  = chainMode;
  end

  // R7: a stop code clears every run and arm bit
  p_stop_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && wrData == '0) |=> (!run1 && !runWide && !armed && !live));
  // R3: the 8-bit counter only ever runs in split layout
  p_run1_split_r3: assert property (@(posedge clk) disable iff (!rstN)
    run1 |-> splitMode);
  // R8: the auto-stop window never passes its limit
  p_auto_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    autoCnt <= AUTO_W'(AUTO_STOP_ETUS));
  // R8: after the last tick of the window nothing runs
  p_auto_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    autoDone |=> (!run1 && !runWide && !live));
endmodule

// File: rtl/tocDatapath.sv
module tocDatapath
  import tocPkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [RELOAD_W-1:0] wrData,
  input  logic                rdStatus,
  input  logic                etuTick,
  input  tocCtl_t             ctl,
  output logic                termWide,
  output logic [1:0]          status,
  output logic                irq
);
  localparam int WIDE_W = NUM_RELOAD * RELOAD_W;
  localparam int MID_W  = 2 * RELOAD_W;
  localparam logic [WIDE_W-1:0] SPLIT_MASK = {{(WIDE_W-MID_W){1'b0}}, {MID_W{1'b1}}};

  logic [WIDE_W-1:0] reloadAll;

  for (genvar i = 0; i < NUM_RELOAD; i++) begin : gReload
    logic [RELOAD_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rstN) val <= '0;
      else if (wrEn && wrAddr == ADDR_W'(ADDR_RELOAD0 + i)) val <= wrData;
    end
    assign reloadAll[i*RELOAD_W +: RELOAD_W] = val;
  end

  logic [1:0] irqMask;
  always_ff @(posedge clk) begin
    if (!rstN) irqMask <= '0;
    else if (wrEn && wrAddr == ADDR_W'(ADDR_MASK)) irqMask <= wrData[1:0];
  end

  logic [RELOAD_W-1:0] shadow1, cnt1;
  logic [WIDE_W-1:0]   cntWide, wideLoad, wideNext;
  logic dec1, term1, decWide;

  always_comb begin
    dec1     = ctl.run1 && etuTick && !ctl.load1;
    term1    = dec1 && (cnt1 == RELOAD_W'(1));
    decWide  = ctl.runWide && etuTick && !ctl.loadWide;
    termWide = decWide && (cntWide == WIDE_W'(1));
    wideLoad = ctl.chained ? reloadAll : (reloadAll >> RELOAD_W);
    wideNext = cntWide - 1'b1;
    if (!ctl.chained) wideNext = wideNext & SPLIT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow1 <= '0;
      cnt1    <= '0;
    end else if (ctl.load1) begin
      shadow1 <= reloadAll[RELOAD_W-1:0];
      cnt1    <= reloadAll[RELOAD_W-1:0];
    end else if (term1) begin
      cnt1 <= shadow1;
    end else if (dec1) begin
      cnt1 <= cnt1 - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cntWide <= '0;
    else if (ctl.loadWide) cntWide <= wideLoad;
    else if (decWide)      cntWide <= wideNext;
  end

  logic [1:0] statusQ;
  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= {termWide, term1} | (rdStatus ? 2'b00 : statusQ);
  end

  assign status = statusQ;
  assign irq    = |(statusQ & irqMask);

  // R2: a terminal count of the 8-bit counter always leaves its flag set
  p_term1_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    term1 |=> statusQ[0]);
  // R9: a read with no terminal count in the same cycle empties the flags
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && !term1 && !termWide) |=> (statusQ == 2'b00));
  // R4: the wide counter halts after its terminal count unless retriggered
  p_wide_halt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (termWide && !ctl.loadWide) |=> !ctl.runWide);
  // R9: flags never drop without a read
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
endmodule

// File: rtl/etuTimeout.sv
module etuTimeout
  import tocPkg::*;
#(
  parameter int RELOAD_W       = 8,
  parameter int ADDR_W         = 3,
  parameter int AUTO_STOP_ETUS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [RELOAD_W-1:0] wrData,
  input  logic                rdStatus,
  input  logic                etuTick,
  input  logic                startBit,
  output logic [1:0]          status,
  output logic                irq
);
  tocCtl_t ctl;
  logic    termWide;

  tocCtrl #(
    .DATA_W(RELOAD_W), .ADDR_W(ADDR_W), .AUTO_STOP_ETUS(AUTO_STOP_ETUS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .startBit(startBit), .etuTick(etuTick), .termWide(termWide), .ctl(ctl)
  );

  tocDatapath #(
    .RELOAD_W(RELOAD_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStatus(rdStatus), .etuTick(etuTick), .ctl(ctl),
    .termWide(termWide), .status(status), .irq(irq)
  );
endmodule

// File: tb/etuTimeout_tb_top.sv
`timescale 1ns/1ps
module etuTimeout_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic rdStatus = 1'b0;
  logic etuTick = 1'b0;
  logic startBit = 1'b0;
  logic [1:0] status;
  logic irq;

  always #2 clk = ~clk;

  etuTimeout dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStatus(rdStatus), .etuTick(etuTick), .startBit(startBit),
    .status(status), .irq(irq)
  );

  typedef struct {
    string    tag;
    logic [1:0] expSt;
    logic [1:0] cmpMask;
    bit       useIrq;
    bit       expIrq;
  } chkItem_t;

  chkItem_t scq[$];
  event evChk;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // Monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(evChk);
      while (scq.size() > 0) begin
        chkItem_t it;
        it = scq.pop_front();
        nChecks++;
        if ((status & it.cmpMask) !== (it.expSt & it.cmpMask)) begin
          nFail++;
          $display("FAIL %s: status actual %b expected %b (mask %b)",
                   it.tag, status, it.expSt, it.cmpMask);
        end else if (it.useIrq && irq !== it.expIrq) begin
          nFail++;
          $display("FAIL %s: irq actual %b expected %b", it.tag, irq, it.expIrq);
        end
      end
    end
  end

  task automatic expectSt(input string tag, input logic [1:0] st,
                          input logic [1:0] msk, input bit useIrq, input bit ei);
    chkItem_t it;
    it.tag = tag; it.expSt = st; it.cmpMask = msk; it.useIrq = useIrq; it.expIrq = ei;
    scq.push_back(it);
    ->evChk;
    #0.1;
  endtask

  task automatic step(input bit t, input bit s, input bit r);
    etuTick = t; startBit = s; rdStatus = r;
    @(negedge clk);
    etuTick = 1'b0; startBit = 1'b0; rdStatus = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expectSt("R1 reset", 2'b00, 2'b11, 1'b1, 1'b0);

    wr(3'd4, 8'h03);
    wr(3'd1, 8'd3);
    wr(3'd2, 8'd5);
    wr(3'd3, 8'd0);

    // R11: start bit before the mode write, then ticks with no start
    step(1'b0, 1'b1, 1'b0);
    ticks(5);
    expectSt("R11 start before mode", 2'b00, 2'b11, 1'b1, 1'b0);
    wr(3'd0, 8'h01);
    ticks(4);
    expectSt("R11 armed without start", 2'b00, 2'b11, 1'b1, 1'b0);

    // R2 / R4 split mode: counter1 = 3, wide = 5
    step(1'b0, 1'b1, 1'b0);
    ticks(2);
    expectSt("R2 before terminal", 2'b00, 2'b11, 1'b1, 1'b0);
    ticks(1);
    expectSt("R2 first timeout", 2'b01, 2'b11, 1'b1, 1'b1);
    ticks(2);
    expectSt("R4 wide timeout", 2'b11, 2'b11, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    expectSt("R9 read clears", 2'b00, 2'b11, 1'b1, 1'b0);
    ticks(1);
    expectSt("R2 auto reload", 2'b01, 2'b11, 1'b0, 1'b0);
    ticks(10);
    expectSt("R4 wide holds after terminal", 2'b00, 2'b10, 1'b0, 1'b0);

    // R3: counter1 has 2 left; a start bit must not retrigger it
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    expectSt("R3 no retrigger yet", 2'b00, 2'b01, 1'b0, 1'b0);
    ticks(1);
    expectSt("R3 counter1 free running", 2'b01, 2'b01, 1'b0, 1'b0);

    // R5: wide holds 3; rewrite middle byte to 2 mid count
    wr(3'd2, 8'd2);
    step(1'b0, 1'b0, 1'b1);
    ticks(2);
    expectSt("R5 running count unaffected", 2'b00, 2'b10, 1'b0, 1'b0);
    ticks(1);
    expectSt("R5 old count completes", 2'b10, 2'b10, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    expectSt("R5 new value pending", 2'b00, 2'b10, 1'b0, 1'b0);
    ticks(1);
    expectSt("R5 new value used", 2'b10, 2'b10, 1'b0, 1'b0);

    // R9: read pulse on the terminal tick, set wins
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    ticks(1);
    step(1'b1, 1'b0, 1'b1);
    expectSt("R9 set wins over clear", 2'b10, 2'b10, 1'b0, 1'b0);

    // R7: stop code and unsupported code
    wr(3'd0, 8'h00);
    step(1'b0, 1'b0, 1'b1);
    ticks(4);
    step(1'b0, 1'b1, 1'b0);
    ticks(10);
    expectSt("R7 stopped by 00h", 2'b00, 2'b11, 1'b1, 1'b0);
    wr(3'd0, 8'h33);
    step(1'b0, 1'b1, 1'b0);
    ticks(10);
    expectSt("R7 unsupported code", 2'b00, 2'b11, 1'b1, 1'b0);

    // R6 chained: {00,01,02} = 258
    wr(3'd1, 8'h02);
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h02);
    step(1'b0, 1'b1, 1'b0);
    ticks(257);
    expectSt("R6 before 24-bit terminal", 2'b00, 2'b11, 1'b1, 1'b0);
    ticks(1);
    expectSt("R6 24-bit terminal", 2'b10, 2'b11, 1'b1, 1'b1);

    // R10: masking
    wr(3'd4, 8'h01);
    expectSt("R10 masked flag", 2'b10, 2'b11, 1'b1, 1'b0);
    wr(3'd4, 8'h02);
    expectSt("R10 enabled flag", 2'b10, 2'b11, 1'b1, 1'b1);
    wr(3'd4, 8'h03);

    // R7: stop in the middle of a chained count
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    ticks(100);
    wr(3'd0, 8'h00);
    ticks(300);
    expectSt("R7 stop mid count", 2'b00, 2'b11, 1'b1, 1'b0);

    // R8 auto-stop: counter1 = 5, wide = 12
    wr(3'd1, 8'd5);
    wr(3'd2, 8'd12);
    wr(3'd3, 8'd0);
    wr(3'd0, 8'h81);
    step(1'b0, 1'b1, 1'b0);
    ticks(5);
    expectSt("R8 counter1 first period", 2'b01, 2'b11, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    ticks(5);
    expectSt("R8 counter1 second period", 2'b01, 2'b11, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    ticks(2);
    expectSt("R8 terminal on 12th tick", 2'b10, 2'b11, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    ticks(10);
    expectSt("R8 stopped after 12 ticks", 2'b00, 2'b11, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    ticks(30);
    expectSt("R8 start ignored after stop", 2'b00, 2'b11, 1'b1, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule